// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs one complete register-style I2C transaction per command on top of a byte-level I2C master. A command carries a 7-bit device address, a register offset of zero, one or two bytes, a direction and a byte count. The sequencer sends the device address and then the offset bytes. For a read with an offset it re-addresses the device with a repeated START and the read bit, then receives the requested bytes. For a write it sends bytes taken from a transmit FIFO.

The lower master is driven with one request per byte (`req_go` plus START, STOP, NAK and receive qualifiers) and answers every request with a one-cycle `ev_done` carrying status flags. Each transaction ends with a single completion pulse that gives a result code and the number of data bytes moved. An error or a timeout while the unit is still busy issues a master abort and passes through a halting phase. A stuck unit or bus found at the start of a command is cleared with a unit reset pulse, and the command is refused if the unit or bus stays busy after it.

Top module: `i2cseq_top`

## Requirements
- R1: After reset `phase_o` is 0 (Idle), `cmd_ready` is 1, and `req_go`, `cpl_valid`, `abort_o` and `unit_rst_o` are 0.
- R2: The first request of a transaction carries START and the byte {device address, direction}, where direction is bit 0 (1 = read). When the offset length is non-zero, this bit is 0.
- R3: Offset bytes are sent most significant byte first. Each one is issued on the `ev_done` of the previous request and carries no START and no STOP.
- R4: In a read with a non-zero offset length, the event after the last offset byte issues a request with START and the byte {device address, 1}. Data receive requests follow.
- R5: Every read data request has `req_rx`=1. The final requested byte carries STOP and NAK, and every earlier byte carries neither. Each received byte appears on `rx_data` with a one-cycle `rx_push`.
- R6: Write data bytes are taken from `tx_data` with one `tx_pop` per byte. STOP is set only on the last byte.
- R7: A read ends early with code 0 when a data event reports NAK, or when `mon_scl` and `mon_sda` are both 1 at that event. The count then equals the data events seen.
- R8: A write ends with code 0 on a NAK event. The count equals the data bytes sent, including the byte that was NAKed.
- R9: A bus-error event gives code 1 and a stop-detect event gives code 2, with the count of data events completed before it. If `unit_busy` is set, `abort_o` pulses, the phase becomes Halting (8), and the next event or timeout returns it to Idle (0). Otherwise the phase becomes Failed (2).
- R10: If `unit_busy` or `bus_busy` is set when a command starts, `unit_rst_o` is high for RST_CYCLES cycles. If either flag is still set after that, the command completes with code 4, count 0 and phase Failed (2), and no request is issued.
- R11: If no `ev_done` arrives within TIMEOUT cycles of the last request or event, the transaction completes with code 3 and follows the abort path of R9.
- R12: Every command produces exactly one `cpl_valid` pulse. A successful end gives code 0 and phase Done (1). A count of 0 ends after the addressing phase with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer finished, command accepted |
| cmd_dev | input | 7 | Device address |
| cmd_sub_len | input | SUBL_W | Offset length in bytes (0..SUB_MAX) |
| cmd_sub | input | 8*SUB_MAX | Register offset |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_count | input | CNT_W | Data byte count |
| req_go | output | 1 | Byte request pulse to the lower master |
| req_data | output | 8 | Byte to send |
| req_start | output | 1 | Issue START before the byte |
| req_stop | output | 1 | Issue STOP after the byte |
| req_nak | output | 1 | Answer a received byte with NAK |
| req_rx | output | 1 | Receive instead of send |
| abort_o | output | 1 | Master abort pulse |
| unit_rst_o | output | 1 | Unit reset to the lower master |
| ev_done | input | 1 | Request or abort finished |
| ev_nak | input | 1 | NAK flagged on this event |
| ev_bus_err | input | 1 | Bus error flagged |
| ev_stop_det | input | 1 | Unexpected STOP flagged |
| ev_rx_data | input | 8 | Received byte |
| unit_busy | input | 1 | Lower master between START and STOP |
| bus_busy | input | 1 | Bus busy |
| mon_scl | input | 1 | SCL line level |
| mon_sda | input | 1 | SDA line level |
| tx_data | input | 8 | Head of transmit FIFO |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_push | output | 1 | Receive byte valid |
| rx_data | output | 8 | Received byte |
| cpl_valid | output | 1 | Completion pulse |
| cpl_code | output | 3 | 0 ok, 1 bus error, 2 stop detect, 3 timeout, 4 refused |
| cpl_count | output | CNT_W | Data bytes transferred |
| phase_o | output | 4 | Current phase |

## Verification
The hardest state to reach is Halting, which needs an error or timeout while the lower master reports itself busy, followed by an abort that may itself go unanswered. The bench's lower-master model can inject bus-error, stop-detect, NAK and bus-idle status at a chosen event index. A hang switch makes the model drop both byte requests and the abort, so the timeout fires twice in a row. Stuck and stale busy flags drive the start-of-command check down both its refuse branch and its recover branch.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_DONE   = 4'd1,
        PH_FAILED = 4'd2,
        PH_BUSY   = 4'd3,
        PH_ADDR   = 4'd4,
        PH_SUB    = 4'd5,
        PH_READ   = 4'd6,
        PH_WRITE  = 4'd7,
        PH_HALT   = 4'd8
    } phase_e;

    typedef enum logic [2:0] {
        CPL_OK      = 3'd0,
        CPL_BUSERR  = 3'd1,
        CPL_STOPDET = 3'd2,
        CPL_TIMEOUT = 3'd3,
        CPL_REFUSED = 3'd4
    } cpl_e;

    function automatic logic ph_finished(phase_e p);
        return (p == PH_IDLE) || (p == PH_DONE) || (p == PH_FAILED);
    endfunction

    function automatic logic ph_on_bus(phase_e p);
        return (p == PH_ADDR) || (p == PH_SUB) || (p == PH_READ) || (p == PH_WRITE);
    endfunction

endpackage

// File: rtl/i2cseq_wdog.sv
module i2cseq_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (cnt != W'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && !clear && (cnt == W'(LIMIT));

    AST_WDOG_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(LIMIT)); // R11

endmodule

// File: rtl/i2cseq_rstpulse.sv
module i2cseq_rstpulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);

    AST_RST_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(start)); // R10

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int MAX_BYTES  = 8192,
    parameter int SUB_MAX    = 2,
    parameter int TIMEOUT    = 1000,
    parameter int RST_CYCLES = 4,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int SUBL_W = $clog2(SUB_MAX + 1),
    localparam int SUB_W  = 8 * SUB_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [6:0]        cmd_dev,
    input  logic [SUBL_W-1:0] cmd_sub_len,
    input  logic [SUB_W-1:0]  cmd_sub,
    input  logic              cmd_read,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              req_go,
    output logic [7:0]        req_data,
    output logic              req_start,
    output logic              req_stop,
    output logic              req_nak,
    output logic              req_rx,
    output logic              abort_o,
    output logic              unit_rst_o,
    input  logic              ev_done,
    input  logic              ev_nak,
    input  logic              ev_bus_err,
    input  logic              ev_stop_det,
    input  logic [7:0]        ev_rx_data,
    input  logic              unit_busy,
    input  logic              bus_busy,
    input  logic              mon_scl,
    input  logic              mon_sda,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [7:0]        rx_data,
    output logic              cpl_valid,
    output logic [2:0]        cpl_code,
    output logic [CNT_W-1:0]  cpl_count,
    output logic [3:0]        phase_o
);
    phase_e              phase;
    logic [6:0]          dev_r;
    logic [SUBL_W-1:0]   sub_left;
    logic [SUB_W-1:0]    sub_r;
    logic                rd_r;
    logic [CNT_W-1:0]    remain;
    logic [CNT_W-1:0]    xfer_cnt;
    logic [CNT_W-1:0]    req_cnt_r;
    logic                rst_done;

    logic                busy_any, ev_err, data_ev, bus_idle;
    logic                cont_data, ends_ok, tmo_hit, rst_go, rst_active;
    logic [CNT_W-1:0]    cnt_next;
    cpl_e                err_code;
    logic [SUB_W+2:0]    sub_shift;
    logic [7:0]          sub_byte;

    assign busy_any  = unit_busy | bus_busy;
    assign ev_err    = ev_bus_err | ev_stop_det;
    assign bus_idle  = mon_scl & mon_sda;
    assign data_ev   = ev_done && !ev_err && (phase == PH_READ || phase == PH_WRITE);
    assign cnt_next  = xfer_cnt + CNT_W'(data_ev);
    assign err_code  = ev_bus_err ? CPL_BUSERR : CPL_STOPDET;
    assign cmd_ready = ph_finished(phase);
    assign phase_o   = phase;

    // Next data step after addressing, or after a data byte that did not end the transfer.
    assign cont_data = ev_done && !ev_err &&
                       ((phase == PH_ADDR) ||
                        (phase == PH_SUB && sub_left == '0 && !rd_r) ||
                        (phase == PH_READ && !ev_nak && !bus_idle) ||
                        (phase == PH_WRITE && !ev_nak));
    assign ends_ok   = (ev_done && !ev_err &&
                        ((phase == PH_READ && (ev_nak || bus_idle)) ||
                         (phase == PH_WRITE && ev_nak))) ||
                       (cont_data && remain == '0);

    assign sub_shift = (SUB_W + 3)'(sub_r >> {sub_left - SUBL_W'(1), 3'b000});
    assign sub_byte  = sub_shift[7:0];

    assign rst_go = (phase == PH_BUSY) && !rst_active && busy_any && !rst_done;

    i2cseq_rstpulse #(.LEN(RST_CYCLES)) u_rst (
        .clk(clk), .rst(rst), .start(rst_go), .active(rst_active)
    );
    assign unit_rst_o = rst_active;

    i2cseq_wdog #(.LIMIT(TIMEOUT)) u_wdog (
        .clk(clk), .rst(rst),
        .run(ph_on_bus(phase) || phase == PH_HALT),
        .clear(ev_done || req_go || abort_o),
        .expired(tmo_hit)
    );

    always_ff @(posedge clk) begin
        req_go    <= 1'b0;
        req_start <= 1'b0;
        req_stop  <= 1'b0;
        req_nak   <= 1'b0;
        req_rx    <= 1'b0;
        tx_pop    <= 1'b0;
        rx_push   <= 1'b0;
        abort_o   <= 1'b0;
        cpl_valid <= 1'b0;
        if (rst) begin
            phase     <= PH_IDLE;
            dev_r     <= '0;
            sub_left  <= '0;
            sub_r     <= '0;
            rd_r      <= 1'b0;
            remain    <= '0;
            xfer_cnt  <= '0;
            req_cnt_r <= '0;
            rst_done  <= 1'b0;
            req_data  <= '0;
            rx_data   <= '0;
            cpl_code  <= '0;
            cpl_count <= '0;
        end else begin
            if (data_ev) xfer_cnt <= cnt_next;
            if (phase == PH_READ && ev_done && !ev_err) begin
                rx_push <= 1'b1;
                rx_data <= ev_rx_data;
            end
            case (phase)
                PH_IDLE, PH_DONE, PH_FAILED: begin
                    if (cmd_valid) begin
                        dev_r     <= cmd_dev;
                        sub_left  <= cmd_sub_len;
                        sub_r     <= cmd_sub;
                        rd_r      <= cmd_read;
                        remain    <= cmd_count;
                        req_cnt_r <= cmd_count;
                        xfer_cnt  <= '0;
                        rst_done  <= 1'b0;
                        phase     <= PH_BUSY;
                    end
                end
                PH_BUSY: begin
                    if (rst_go) begin
                        rst_done <= 1'b1;
                    end else if (!rst_active) begin
                        if (!busy_any) begin
                            req_go    <= 1'b1;
                            req_start <= 1'b1;
                            req_data  <= {dev_r, (sub_left != '0) ? 1'b0 : rd_r};
                            phase     <= (sub_left != '0) ? PH_SUB : PH_ADDR;
                        end else if (rst_done) begin
                            cpl_valid <= 1'b1;
                            cpl_code  <= CPL_REFUSED;
                            cpl_count <= '0;
                            phase     <= PH_FAILED;
                        end
                    end
                end
                PH_ADDR, PH_SUB, PH_READ, PH_WRITE: begin
                    if ((ev_done && ev_err) || (!ev_done && tmo_hit)) begin
                        cpl_valid <= 1'b1;
                        cpl_code  <= ev_done ? err_code : CPL_TIMEOUT;
                        cpl_count <= xfer_cnt;
                        if (unit_busy) begin
                            abort_o <= 1'b1;
                            phase   <= PH_HALT;
                        end else begin
                            phase   <= PH_FAILED;
                        end
                    end else if (ends_ok) begin
                        cpl_valid <= 1'b1;
                        cpl_code  <= CPL_OK;
                        cpl_count <= cnt_next;
                        phase     <= PH_DONE;
                    end else if (cont_data) begin
                        req_go   <= 1'b1;
                        remain   <= remain - 1'b1;
                        req_stop <= (remain == CNT_W'(1));
                        if (rd_r) begin
                            req_rx   <= 1'b1;
                            req_nak  <= (remain == CNT_W'(1));
                            req_data <= '0;
                            phase    <= PH_READ;
                        end else begin
                            req_data <= tx_data;
                            tx_pop   <= 1'b1;
                            phase    <= PH_WRITE;
                        end
                    end else if (ev_done && phase == PH_SUB && sub_left != '0) begin
                        req_go   <= 1'b1;
                        req_data <= sub_byte;
                        sub_left <= sub_left - 1'b1;
                    end else if (ev_done && phase == PH_SUB) begin
                        req_go    <= 1'b1;
                        req_start <= 1'b1;
                        req_data  <= {dev_r, 1'b1};
                        phase     <= PH_ADDR;
                    end
                end
                PH_HALT: begin
                    if (ev_done || tmo_hit) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_LAST_RX_NAK: assert property (@(posedge clk) disable iff (rst)
        (req_go && req_rx) |-> (req_stop == req_nak)); // R5
    AST_START_NOT_RX: assert property (@(posedge clk) disable iff (rst)
        (req_go && req_start) |-> !req_rx); // R2
    AST_CPL_PHASE: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (phase == PH_DONE || phase == PH_FAILED || phase == PH_HALT)); // R12
    AST_ERR_FAILS: assert property (@(posedge clk) disable iff (rst)
        (ev_done && ev_err && ph_on_bus(phase)) |=> (cpl_valid && cpl_code != CPL_OK)); // R9
    AST_HALT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HALT && ev_done) |=> (phase == PH_IDLE)); // R9
    AST_RST_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        unit_rst_o |-> (phase == PH_BUSY)); // R10
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (cpl_count <= req_cnt_r)); // R8

endmodule

// File: tb/i2cseq_top_test.sv
module i2cseq_top_test;

    typedef struct packed {
        logic [6:0]  dev;
        logic [1:0]  sl;
        logic [15:0] sub;
        logic        rd;
        logic [13:0] cnt;
        logic [7:0]  nak_at;
        logic [7:0]  err_at;
        logic [1:0]  ek;
        logic [7:0]  idle_at;
        logic [2:0]  ecode;
        logic [13:0] ecount;
        logic [7:0]  enreq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{7'h21, 2'd0, 16'h0000, 1'b0, 14'd3, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd3, 8'd4},
        '{7'h30, 2'd1, 16'h00AB, 1'b0, 14'd2, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd2, 8'd4},
        '{7'h50, 2'd2, 16'h1234, 1'b1, 14'd3, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd3, 8'd7},
        '{7'h11, 2'd0, 16'h0000, 1'b1, 14'd1, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd1, 8'd2},
        '{7'h42, 2'd2, 16'hBEEF, 1'b0, 14'd4, 8'd4,  8'hFF, 2'd0, 8'hFF, 3'd0, 14'd2, 8'd5},
        '{7'h19, 2'd0, 16'h0000, 1'b1, 14'd5, 8'd2,  8'hFF, 2'd0, 8'hFF, 3'd0, 14'd2, 8'd3},
        '{7'h1A, 2'd0, 16'h0000, 1'b1, 14'd5, 8'hFF, 8'hFF, 2'd0, 8'd3,  3'd0, 14'd3, 8'd4},
        '{7'h2B, 2'd1, 16'h0077, 1'b1, 14'd2, 8'hFF, 8'd2,  2'd1, 8'hFF, 3'd1, 14'd0, 8'd3},
        '{7'h2C, 2'd0, 16'h0000, 1'b0, 14'd3, 8'hFF, 8'd2,  2'd2, 8'hFF, 3'd2, 14'd1, 8'd3},
        '{7'h3D, 2'd0, 16'h0000, 1'b0, 14'd0, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd0, 8'd1},
        '{7'h3E, 2'd2, 16'h5566, 1'b1, 14'd0, 8'hFF, 8'hFF, 2'd0, 8'hFF, 3'd0, 14'd0, 8'd4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready, cmd_read = 1'b0;
    logic [6:0]  cmd_dev = '0;
    logic [1:0]  cmd_sub_len = '0;
    logic [15:0] cmd_sub = '0;
    logic [13:0] cmd_count = '0;
    logic        req_go, req_start, req_stop, req_nak, req_rx, abort_o, unit_rst_o;
    logic [7:0]  req_data;
    logic        ev_done = 1'b0, ev_nak = 1'b0, ev_bus_err = 1'b0, ev_stop_det = 1'b0;
    logic [7:0]  ev_rx_data = '0;
    logic        mon_scl = 1'b0, mon_sda = 1'b0;
    logic        unit_busy, bus_busy;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_push, cpl_valid;
    logic [7:0]  rx_data;
    logic [2:0]  cpl_code;
    logic [13:0] cpl_count;
    logic [3:0]  phase_o;

    i2cseq_top #(.TIMEOUT(40), .RST_CYCLES(4)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dev(cmd_dev), .cmd_sub_len(cmd_sub_len), .cmd_sub(cmd_sub),
        .cmd_read(cmd_read), .cmd_count(cmd_count),
        .req_go(req_go), .req_data(req_data), .req_start(req_start), .req_stop(req_stop),
        .req_nak(req_nak), .req_rx(req_rx), .abort_o(abort_o), .unit_rst_o(unit_rst_o),
        .ev_done(ev_done), .ev_nak(ev_nak), .ev_bus_err(ev_bus_err), .ev_stop_det(ev_stop_det),
        .ev_rx_data(ev_rx_data), .unit_busy(unit_busy), .bus_busy(bus_busy),
        .mon_scl(mon_scl), .mon_sda(mon_sda), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .cpl_valid(cpl_valid), .cpl_code(cpl_code),
        .cpl_count(cpl_count), .phase_o(phase_o)
    );

    // Bench-side configuration of the lower-master model
    logic [7:0] cfg_nak = 8'hFF, cfg_err = 8'hFF, cfg_idle = 8'hFF;
    logic [1:0] cfg_ek = '0;
    logic       hang = 1'b0, stuck = 1'b0, stale = 1'b0;

    // Lower-master model state
    logic       ubusy, pend, pend_stop, pend_rx, pend_abort, stale_r;
    int         lat, evn, rxn, nlog, npop, nrx, nrst, naborts;
    logic [11:0] lg [64];
    logic [7:0]  rxl [64];

    assign unit_busy = ubusy | stuck | stale_r;
    assign bus_busy  = ubusy | stuck | stale_r;
    assign tx_data   = 8'h50 + 8'(npop);

    always @(posedge clk) begin
        ev_done <= 1'b0; ev_nak <= 1'b0; ev_bus_err <= 1'b0; ev_stop_det <= 1'b0;
        mon_scl <= 1'b0; mon_sda <= 1'b0;
        if (rst) begin
            ubusy <= 1'b0; pend <= 1'b0; pend_abort <= 1'b0; pend_stop <= 1'b0; pend_rx <= 1'b0;
            stale_r <= 1'b0; lat <= 0; evn <= 0; rxn <= 0; nlog <= 0; npop <= 0; nrx <= 0;
            nrst <= 0; naborts <= 0;
        end else begin
            if (stale) stale_r <= 1'b1;
            if (cmd_valid && cmd_ready) begin
                evn <= 0; rxn <= 0; nlog <= 0; npop <= 0; nrx <= 0; nrst <= 0; naborts <= 0;
            end
            if (unit_rst_o) begin
                ubusy <= 1'b0; stale_r <= 1'b0; nrst <= nrst + 1;
            end
            if (tx_pop) npop <= npop + 1;
            if (rx_push) begin rxl[nrx[5:0]] <= rx_data; nrx <= nrx + 1; end
            if (abort_o) naborts <= naborts + 1;
            if (req_go) begin
                lg[nlog[5:0]] <= {req_data, req_start, req_stop, req_nak, req_rx};
                nlog <= nlog + 1;
                if (req_start) ubusy <= 1'b1;
                if (!hang) begin
                    pend <= 1'b1; lat <= 3; pend_stop <= req_stop; pend_rx <= req_rx;
                end
            end else if (abort_o && !hang) begin
                pend <= 1'b1; lat <= 3; pend_abort <= 1'b1; pend_stop <= 1'b0; pend_rx <= 1'b0;
            end
            if (pend) begin
                if (lat == 0) begin
                    pend <= 1'b0;
                    ev_done <= 1'b1;
                    if (pend_abort) begin
                        pend_abort <= 1'b0;
                        ubusy <= 1'b0;
                    end else begin
                        ev_nak      <= (8'(evn) == cfg_nak);
                        ev_bus_err  <= (8'(evn) == cfg_err) && (cfg_ek == 2'd1);
                        ev_stop_det <= (8'(evn) == cfg_err) && (cfg_ek == 2'd2);
                        mon_scl     <= (8'(evn) == cfg_idle);
                        mon_sda     <= (8'(evn) == cfg_idle);
                        ev_rx_data  <= 8'hA0 + 8'(rxn);
                        if (pend_rx) rxn <= rxn + 1;
                        if (pend_stop) ubusy <= 1'b0;
                        evn <= evn + 1;
                    end
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [2:0]  got_code;
    logic [13:0] got_count;
    bit          got_cpl;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_tests = n_tests + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_req(vec_t v, int i);
        int k;
        int sl;
        int j;
        logic [7:0] b;
        sl = int'(v.sl);
        k = i;
        if (k == 0) return {v.dev, (sl != 0) ? 1'b0 : v.rd, 1'b1, 1'b0, 1'b0, 1'b0};
        k = k - 1;
        if (k < sl) begin
            b = 8'(v.sub >> (8 * (sl - 1 - k)));
            return {b, 4'b0000};
        end
        k = k - sl;
        if (v.rd && sl != 0) begin
            if (k == 0) return {v.dev, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            k = k - 1;
        end
        j = k;
        if (v.rd) return {8'h00, 1'b0, (j == int'(v.cnt) - 1), (j == int'(v.cnt) - 1), 1'b1};
        return {8'h50 + 8'(j), 1'b0, (j == int'(v.cnt) - 1), 1'b0, 1'b0};
    endfunction

    task automatic run_cmd(input vec_t v);
        cfg_nak = v.nak_at; cfg_err = v.err_at; cfg_ek = v.ek; cfg_idle = v.idle_at;
        @(negedge clk);
        for (int w = 0; w < 2000 && !cmd_ready; w++) @(negedge clk);
        cmd_dev = v.dev; cmd_sub_len = v.sl; cmd_sub = v.sub; cmd_read = v.rd;
        cmd_count = v.cnt; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_cpl = 1'b0;
        for (int w = 0; w < 3000 && !got_cpl; w++) begin
            if (cpl_valid) begin
                got_cpl = 1'b1; got_code = cpl_code; got_count = cpl_count;
            end else begin
                @(negedge clk);
            end
        end
        for (int w = 0; w < 100; w++) @(negedge clk);
    endtask

    initial begin
        vec_t v;
        int bad;
        int exp_pops;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 phase", 32'(phase_o), 32'd0);
        chk("R1 ready/outputs", {28'd0, cmd_ready, req_go, cpl_valid, abort_o | unit_rst_o}, 32'h8);

        for (int n = 0; n < NV; n++) begin
            v = VT[n];
            run_cmd(v);
            chk($sformatf("R12 completion v%0d", n), 32'(got_cpl), 32'd1);
            chk($sformatf("R12/R9 code v%0d", n), 32'(got_code), 32'(v.ecode));
            chk($sformatf("R7/R8 count v%0d", n), 32'(got_count), 32'(v.ecount));
            chk($sformatf("R2-R6 request count v%0d", n), 32'(nlog), 32'(v.enreq));
            bad = 0;
            for (int i = 0; i < nlog && i < 64; i++) begin
                logic [11:0] e;
                logic [11:0] a;
                e = exp_req(v, i);
                a = lg[i];
                if (e[0]) begin e[11:4] = 8'h00; a[11:4] = 8'h00; end
                if (a !== e) begin
                    bad = bad + 1;
                    $display("FAIL R2/R3/R4/R5/R6 v%0d req%0d: actual=%0h expected=%0h", n, i, a, e);
                end
            end
            n_tests = n_tests + 1;
            if (bad != 0) n_fail = n_fail + 1;
            if (v.rd) begin
                chk($sformatf("R5 rx bytes v%0d", n), 32'(nrx), 32'(v.ecount));
                for (int k = 0; k < nrx && k < 64; k++)
                    chk($sformatf("R5 rx data v%0d b%0d", n, k), 32'(rxl[k]), 32'(8'hA0 + 8'(k)));
            end else begin
                exp_pops = int'(v.enreq) - 1 - int'(v.sl);
                if (exp_pops < 0) exp_pops = 0;
                chk($sformatf("R6 pops v%0d", n), 32'(npop), 32'(exp_pops));
            end
            if (v.ecode != 3'd0) begin
                chk($sformatf("R9 abort v%0d", n), 32'(naborts), 32'd1);
                chk($sformatf("R9 back to idle v%0d", n), 32'(phase_o), 32'd0);
            end else begin
                chk($sformatf("R12 done phase v%0d", n), 32'(phase_o), 32'd1);
            end
        end

        // R10: stale busy is cleared by the unit reset and the command proceeds
        stale = 1'b1;
        @(negedge clk);
        stale = 1'b0;
        run_cmd(VT[0]);
        chk("R10 recover code", 32'(got_code), 32'd0);
        chk("R10 recover reset length", 32'(nrst), 32'd4);

        // R10: busy that survives the reset refuses the command
        stuck = 1'b1;
        run_cmd(VT[1]);
        chk("R10 refuse code", 32'(got_code), 32'd4);
        chk("R10 refuse count", 32'(got_count), 32'd0);
        chk("R10 refuse no request", 32'(nlog), 32'd0);
        chk("R10 refuse reset length", 32'(nrst), 32'd4);
        chk("R10 refuse phase", 32'(phase_o), 32'd2);
        stuck = 1'b0;

        // R11: no answer from the lower master, then no answer to the abort either
        hang = 1'b1;
        run_cmd(VT[0]);
        chk("R11 timeout code", 32'(got_code), 32'd3);
        chk("R11 timeout count", 32'(got_count), 32'd0);
        chk("R11 timeout abort", 32'(naborts), 32'd1);
        chk("R11 halting times out to idle", 32'(phase_o), 32'd0);
        hang = 1'b0;

        // R12: after recovery a normal read still works
        run_cmd(VT[3]);
        chk("R12 post-timeout read code", 32'(got_code), 32'd0);
        chk("R12 post-timeout read count", 32'(got_count), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule